// File: doc/BRIEF.md
# Page-Level ECC Chunk Status Aggregator

A NAND page is corrected in chunks, and the correction engine leaves one status byte for each chunk. This block takes those bytes one at a time and works out what the whole page did. It reports the largest bit-flip count seen in any single chunk, the sum of all corrected bits, how many chunks could not be corrected, and whether the page failed as a whole.

A host pulses `page_start` with the first chunk byte, or at any earlier point. It then streams the bytes with `st_valid` and marks the final one with `st_last`. One clock later, `res_valid` pulses for a single cycle. The result fields stay unchanged until the next page ends.

Two codes are special. The code 0xFF marks an erased chunk, which counts as neither an error nor a failure. The code 0xFE marks a chunk the engine could not fix. Any other value above the correctable ceiling of 40 is also taken as a failure, not as a count.

Top module: `chunk_stat_agg`

## Requirements
- R1: After reset, `res_valid` is 0 and `res_max`, `res_total`, `res_fail_cnt` and `res_fail` are all 0.
- R2: A status byte of 0x00 adds nothing to the total and causes no failure.
- R3: A status byte from 1 to 40 adds its value to `res_total` and raises `res_max` when it is larger than every earlier chunk of the page.
- R4: A status byte of 0xFF (erased) leaves the total, the maximum and the failure count unchanged, and it is not a failure.
- R5: A status byte of 0xFE adds one to `res_fail_cnt` and sets `res_fail`.
- R6: Every status byte from 41 to 0xFD is handled as a failure in the same way as 0xFE, and nothing is added to the total.
- R7: `res_fail` is 1 exactly when `res_fail_cnt` is non-zero. While `res_fail` is 1, `res_max` reads 0. Otherwise `res_max` gives the largest per-chunk count of the page.
- R8: `res_valid` is high for exactly one cycle, the cycle after the byte with `st_last` is accepted. The result fields hold their values until the next such strobe.
- R9: `page_start` clears all accumulators. A byte accepted in the same cycle as `page_start` is counted as the first chunk of the new page.
- R10: `res_total` holds 16 chunks of 40 corrected bits each, a total of 640, without wrapping.
- R11: While `st_valid` is low, `st_byte` and `st_last` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| page_start | input | 1 | Clears the accumulators for a new page |
| st_valid | input | 1 | A chunk status byte is present |
| st_byte | input | 8 | Chunk status byte |
| st_last | input | 1 | This byte is the page's final chunk |
| res_valid | output | 1 | One-cycle page result strobe |
| res_max | output | 6 | Largest per-chunk correction count, 0 when the page failed |
| res_total | output | 10 | Sum of corrected bits over the page |
| res_fail_cnt | output | 5 | Number of uncorrectable chunks |
| res_fail | output | 1 | The page has at least one uncorrectable chunk |

## Verification
The clear from `page_start` and the accumulation of an incoming byte can fall in the same cycle. The clear can also coincide with a byte tagged last. The bench sweeps all 256 status values as single-chunk pages, each sent with `page_start`, `st_valid` and `st_last` all high in one cycle. It judges the result against an arithmetic decode of the byte alone, so any value left over from the page before shows up as a mismatch. A second case starts a page partway through a failing partial page, and expects the new page to carry none of the abandoned state.

// File: rtl/chunk_stat_agg.sv
module chunk_stat_agg #(
  parameter int MAX_CHUNKS  = 16,
  parameter int MAX_CORR    = 40,
  parameter int ERASED_CODE = 8'hFF,
  parameter int UNCORR_CODE = 8'hFE,
  localparam int TOT_W = $clog2(MAX_CHUNKS * MAX_CORR + 1),
  localparam int CNT_W = $clog2(MAX_CHUNKS + 1),
  localparam int MAX_W = $clog2(MAX_CORR + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             page_start,
  input  logic             st_valid,
  input  logic [7:0]       st_byte,
  input  logic             st_last,
  output logic             res_valid,
  output logic [MAX_W-1:0] res_max,
  output logic [TOT_W-1:0] res_total,
  output logic [CNT_W-1:0] res_fail_cnt,
  output logic             res_fail
);

  logic [MAX_W-1:0] acc_max, base_max, nxt_max, hold_max;
  logic [TOT_W-1:0] acc_total, base_total, nxt_total;
  logic [CNT_W-1:0] acc_fail, base_fail, nxt_fail;
  logic             is_erased, is_uncorr, is_corr, is_fail;
  logic [MAX_W-1:0] corr_bits;

  assign is_erased = st_byte == 8'(ERASED_CODE);
  assign is_uncorr = st_byte == 8'(UNCORR_CODE);
  assign is_corr   = st_byte <= 8'(MAX_CORR);
  assign is_fail   = is_uncorr | (!is_erased & !is_corr);
  assign corr_bits = (st_valid && is_corr) ? st_byte[MAX_W-1:0] : '0;

  assign base_max   = page_start ? '0 : acc_max;
  assign base_total = page_start ? '0 : acc_total;
  assign base_fail  = page_start ? '0 : acc_fail;

  assign nxt_max   = (corr_bits > base_max) ? corr_bits : base_max;
  assign nxt_total = base_total + TOT_W'(corr_bits);
  assign nxt_fail  = base_fail + CNT_W'(st_valid && is_fail);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_max   <= '0;
      acc_total <= '0;
      acc_fail  <= '0;
    end else if (page_start || st_valid) begin
      acc_max   <= nxt_max;
      acc_total <= nxt_total;
      acc_fail  <= nxt_fail;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      hold_max     <= '0;
      res_total    <= '0;
      res_fail_cnt <= '0;
    end else begin
      res_valid <= st_valid && st_last;
      if (st_valid && st_last) begin
        hold_max     <= nxt_max;
        res_total    <= nxt_total;
        res_fail_cnt <= nxt_fail;
      end
    end
  end

  assign res_fail = res_fail_cnt != '0;
  assign res_max  = res_fail ? '0 : hold_max;

endmodule

// File: rtl/chunk_stat_agg_chk.sv
module chunk_stat_agg_chk #(
  parameter int MAX_CHUNKS = 16,
  parameter int MAX_CORR   = 40,
  localparam int TOT_W = $clog2(MAX_CHUNKS * MAX_CORR + 1),
  localparam int CNT_W = $clog2(MAX_CHUNKS + 1),
  localparam int MAX_W = $clog2(MAX_CORR + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_valid,
  input logic             st_last,
  input logic             res_valid,
  input logic [MAX_W-1:0] res_max,
  input logic [TOT_W-1:0] res_total,
  input logic [CNT_W-1:0] res_fail_cnt,
  input logic             res_fail
);

  // R8
  strobe_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_last) |=> res_valid);

  // R8
  strobe_needs_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(st_valid && st_last));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_total) && $stable(res_fail_cnt)));

  // R7
  fail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_fail == (res_fail_cnt != '0));

  // R7
  fail_max_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_fail |-> res_max == '0);

  // R3
  max_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_max <= MAX_W'(MAX_CORR));

  // R3
  total_covers_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    TOT_W'(res_max) <= res_total);

endmodule

bind chunk_stat_agg chunk_stat_agg_chk #(.MAX_CHUNKS(MAX_CHUNKS), .MAX_CORR(MAX_CORR)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_last(st_last),
  .res_valid(res_valid), .res_max(res_max), .res_total(res_total),
  .res_fail_cnt(res_fail_cnt), .res_fail(res_fail)
);

// File: tb/tb_chunk_stat_agg.sv
module tb_chunk_stat_agg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       page_start = 1'b0;
  logic       st_valid = 1'b0;
  logic [7:0] st_byte = 8'h00;
  logic       st_last = 1'b0;
  logic       res_valid;
  logic [5:0] res_max;
  logic [9:0] res_total;
  logic [4:0] res_fail_cnt;
  logic       res_fail;

  int checks = 0;
  int failures = 0;
  int pg[16];

  chunk_stat_agg dut (
    .clk(clk), .rst_n(rst_n), .page_start(page_start), .st_valid(st_valid),
    .st_byte(st_byte), .st_last(st_last), .res_valid(res_valid),
    .res_max(res_max), .res_total(res_total), .res_fail_cnt(res_fail_cnt),
    .res_fail(res_fail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_page(string req, int n);
    int mx = 0, tot = 0, fl = 0;
    for (int i = 0; i < n; i++) begin
      if (pg[i] <= 40) begin
        tot += pg[i];
        if (pg[i] > mx) mx = pg[i];
      end else if (pg[i] != 8'hFF) fl++;
    end
    chk({req, " strobe"}, int'(res_valid), 1);
    chk({req, " max"}, int'(res_max), fl != 0 ? 0 : mx);
    chk({req, " total"}, int'(res_total), tot);
    chk({req, " failcnt"}, int'(res_fail_cnt), fl);
    chk({req, " flag"}, int'(res_fail), fl != 0 ? 1 : 0);
  endtask

  task automatic run_page(string req, int n, bit with_start);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      page_start = with_start && (i == 0);
      st_valid = 1'b1;
      st_byte = 8'(pg[i]);
      st_last = (i == n - 1);
    end
    @(negedge clk);
    page_start = 1'b0; st_valid = 1'b0; st_last = 1'b0;
    expect_page(req, n);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", int'(res_valid), 0);
    chk("R1 max", int'(res_max), 0);
    chk("R1 total", int'(res_total), 0);
    chk("R1 failcnt", int'(res_fail_cnt), 0);
    chk("R1 flag", int'(res_fail), 0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R9: every code as a one-chunk page, start in the same cycle
    for (int v = 0; v < 256; v++) begin
      pg[0] = v;
      if (v == 0) run_page("R2", 1, 1'b1);
      else if (v <= 40) run_page("R3", 1, 1'b1);
      else if (v == 255) run_page("R4", 1, 1'b1);
      else if (v == 254) run_page("R5", 1, 1'b1);
      else run_page("R6", 1, 1'b1);
    end

    // R8: strobe falls after one cycle, fields hold
    pg[0] = 12; pg[1] = 7; pg[2] = 0;
    run_page("R3 mixed", 3, 1'b1);
    @(negedge clk);
    chk("R8 single pulse", int'(res_valid), 0);
    chk("R8 hold total", int'(res_total), 19);
    chk("R8 hold max", int'(res_max), 12);

    // R10: 16 chunks of 40
    for (int i = 0; i < 16; i++) pg[i] = 40;
    run_page("R10", 16, 1'b1);

    // R4 R7: erased chunks among corrected ones, then a failing mixture
    for (int i = 0; i < 16; i++) pg[i] = (i % 3 == 0) ? 255 : i;
    run_page("R4 mix", 16, 1'b1);
    for (int i = 0; i < 16; i++) pg[i] = (i % 5 == 2) ? 200 + i : 30 - i;
    run_page("R7 fail mix", 16, 1'b1);

    // R9: abandon a failing partial page, restart
    @(negedge clk); page_start = 1'b1; st_valid = 1'b1; st_byte = 8'hFE; st_last = 1'b0;
    @(negedge clk); page_start = 1'b0; st_byte = 8'd33;
    pg[0] = 5; pg[1] = 9;
    run_page("R9 restart", 2, 1'b1);

    // R11: junk with valid low must not count
    @(negedge clk); page_start = 1'b1; st_valid = 1'b1; st_byte = 8'd7; st_last = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); page_start = 1'b0; st_valid = 1'b0; st_byte = 8'hFE; st_last = 1'b1;
      chk("R11 no strobe", int'(res_valid), 0);
    end
    pg[0] = 7; pg[1] = 9;
    @(negedge clk); st_valid = 1'b1; st_byte = 8'd9; st_last = 1'b1;
    @(negedge clk); st_valid = 1'b0; st_last = 1'b0;
    expect_page("R11", 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule